// File: doc/BRIEF.md
# Escalating Multi-Level Watchdog

This block is a watchdog whose timeout runs through a chain of escalation levels instead of a single countdown. A microsecond tick timer, derived from the core clock by a prescaler, produces one expiry event per programmed period. While the watchdog is running, each expiry moves it to the next level and latches that level's action: first a local interrupt, then a fast interrupt, a remote interrupt, a debug reset and finally a power-on reset. Software that is alive restarts the sequence with a start command before the later levels are reached. The total time to the final reset is the per-level period times the number of levels actually visited.

Each action has its own enable in a configuration register, and a skip register lets any level jump over a number of the levels after it, so the chain can be shortened. An error output rises once the level count reaches a programmable threshold. Stopping the watchdog is guarded: the stop command works only straight after a key word has been written to an unlock register. Once the local interrupt enable has been set, the configuration register is frozen until reset.

All registers sit on a simple single-cycle write bus with a combinational read port addressed by a 3-bit word address.

Top module: `wdogTop`

## Requirements
- R1: Reload register (address 0): bits 28:0 hold the period in microseconds, bit 31 enables the tick timer and bit 30 selects auto-reload; with bit 30 clear the timer expires once and then stays quiet until the reload register is written again or a start command is given.
- R2: Timer status register (address 1): bit 30 is set by every timer expiry and is cleared by writing 1 to bit 30; other bits read 0.
- R3: A period of zero with the enable bit set produces no expiry: the timer status bit stays clear and the level never advances.
- R4: While running, each expiry fires the current level and advances it; the levels fire in the order local interrupt (output irqLocal), fast interrupt (irqFast), remote interrupt (irqRemote), debug reset (rstDebug), power-on reset (rstPor); a fired action stays asserted, and is driven only if its enable bit in the config register (address 2) is set: bit 12, 13, 14, 15, 16 respectively. After the fifth level no more levels fire, and expiries while not running fire nothing.
- R5: Config bits 22:20 hold an error threshold; errOut is high whenever the count of levels passed is greater than or equal to it. The config register resets to 0x0070_0000.
- R6: Writing a command (address 4) with bit 0 set starts the watchdog, returns it to level zero, drops every fired action and restarts the full timer period.
- R7: Writing a command with bit 1 set stops the watchdog and drops all actions only if the write just before it was 0x0000_C45A to the unlock register (address 5); otherwise the stop is ignored. A stop that is honoured overrides a start bit in the same write.
- R8: The unlock state is single-use: any bus write other than the key to the unlock register clears it.
- R9: Skip register (address 6): level i owns the 3-bit field at bits 4i+2:4i; when level i fires, that many following levels are bypassed (the level saturates at five); the register reads back as written in those fields.
- R10: Watchdog status register (address 3): bit 1 reads 1 once the local-interrupt level has fired since the last start or stop, whether or not its action is enabled.
- R11: Once config bit 12 is 1 the config register ignores all writes until reset; only bits 3:0, 4, 16:12 and 22:20 are stored.
- R12: The reload register reads back the last value written; the command and unlock registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqLocal | output | 1 | Level-one action, local interrupt |
| irqFast | output | 1 | Level-two action, fast interrupt |
| irqRemote | output | 1 | Level-three action, remote interrupt |
| rstDebug | output | 1 | Level-four action, debug reset request |
| rstPor | output | 1 | Level-five action, power-on reset request |
| errOut | output | 1 | Level count at or above the error threshold |

## Verification
The hardest state to reach is a fully escalated watchdog that then faces the guarded stop, because it needs five real timer periods and the unlock key must be immediately followed by the stop. The bench shortens the prescaler so that a period lasts sixteen clocks, drives the chain to the last level, and then offers a bare stop, an unlock broken by an unrelated write, and finally a proper unlock-stop pair, watching the held actions at each step. Skip and restart are reached from the same fast timing, sampling each level in the middle of its period so no check sits on an edge.

// File: rtl/wdogPkg.sv
package wdogPkg;
  localparam int NUM_LEVELS = 5;
  localparam int SKIP_W     = 3;
  localparam int PERIOD_W   = 29;
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1);

  localparam logic [2:0] ADDR_RELOAD = 3'd0;
  localparam logic [2:0] ADDR_TSTAT  = 3'd1;
  localparam logic [2:0] ADDR_CFG    = 3'd2;
  localparam logic [2:0] ADDR_WSTAT  = 3'd3;
  localparam logic [2:0] ADDR_CMD    = 3'd4;
  localparam logic [2:0] ADDR_UNLOCK = 3'd5;
  localparam logic [2:0] ADDR_SKIP   = 3'd6;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;
  localparam logic [31:0] CFG_MASK   = 32'h0071_F01F;
  localparam logic [31:0] CFG_RESET  = 32'h0070_0000;

  localparam int RLD_EN_BIT   = 31;
  localparam int RLD_AUTO_BIT = 30;
  localparam int PEND_BIT     = 30;
  localparam int CFG_ACT_LSB  = 12;
  localparam int CFG_THR_LSB  = 20;

  typedef logic [NUM_LEVELS-1:0][SKIP_W-1:0] skipArr_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic clrPend;
    logic timerRestart;
  } strobe_t;
endpackage

// File: rtl/wdogCtrl.sv
module wdogCtrl
  import wdogPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  input  logic        pendQ,
  input  logic        localHit,
  output logic [31:0] busRdata,
  output logic [31:0] reloadQ,
  output logic [31:0] cfgQ,
  output skipArr_t    skipQ,
  output strobe_t     strb,
  output logic        unlockedQ,
  output logic        cfgLocked
);
  logic [31:0] skipRd;
  logic        wrCmd;

  assign cfgLocked = cfgQ[CFG_ACT_LSB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ   <= '0;
      cfgQ      <= CFG_RESET;
      skipQ     <= '0;
      unlockedQ <= 1'b0;
    end else if (busWe) begin
      unlockedQ <= (busAddr == ADDR_UNLOCK) && (busWdata == UNLOCK_KEY);
      case (busAddr)
        ADDR_RELOAD: reloadQ <= busWdata;
        ADDR_CFG:    if (!cfgLocked) cfgQ <= busWdata & CFG_MASK;
        ADDR_SKIP:   for (int i = 0; i < NUM_LEVELS; i++) skipQ[i] <= busWdata[4*i +: SKIP_W];
        default: ;
      endcase
    end
  end

  always_comb begin
    wrCmd             = busWe && (busAddr == ADDR_CMD);
    strb.stop         = wrCmd && busWdata[1] && unlockedQ;
    strb.start        = wrCmd && busWdata[0] && !strb.stop;
    strb.clrPend      = busWe && (busAddr == ADDR_TSTAT) && busWdata[PEND_BIT];
    strb.timerRestart = (busWe && (busAddr == ADDR_RELOAD)) || strb.start;
  end

  generate
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : gSkipRd
      assign skipRd[4*i +: 4] = {1'b0, skipQ[i]};
    end
    if (4 * NUM_LEVELS < 32) begin : gSkipPad
      assign skipRd[31:4*NUM_LEVELS] = '0;
    end
  endgenerate

  always_comb begin
    case (busAddr)
      ADDR_RELOAD: busRdata = reloadQ;
      ADDR_TSTAT:  busRdata = {1'b0, pendQ, 30'd0};
      ADDR_CFG:    busRdata = cfgQ;
      ADDR_WSTAT:  busRdata = {30'd0, localHit, 1'b0};
      ADDR_SKIP:   busRdata = skipRd;
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdogPkg::*;
#(
  parameter int CLKS_PER_US = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [31:0]           reloadQ,
  input  logic [NUM_LEVELS-1:0] actEn,
  input  logic [2:0]            errThresh,
  input  skipArr_t              skipQ,
  output logic                  pendQ,
  output logic                  runQ,
  output logic [LVL_W-1:0]      levelQ,
  output logic [NUM_LEVELS-1:0] firedQ,
  output logic [NUM_LEVELS-1:0] actOut,
  output logic                  errOut
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
  localparam int SUM_W = LVL_W + 1;
  localparam logic [SUM_W-1:0] LVL_MAX_S = SUM_W'(NUM_LEVELS);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_LEVELS);

  logic [PRE_W-1:0]    preQ;
  logic [PERIOD_W-1:0] tcntQ, period;
  logic                spentQ, timerActive, usTick, expire;
  logic [SKIP_W-1:0]   curSkip;
  logic [SUM_W-1:0]    levelSum;
  logic [LVL_W-1:0]    nextLevel;
  logic [NUM_LEVELS-1:0] firedNext;

  assign period      = reloadQ[PERIOD_W-1:0];
  assign timerActive = reloadQ[RLD_EN_BIT] && (period != '0) && !spentQ;
  assign usTick      = timerActive && (preQ == PRE_LAST);
  assign expire      = usTick && (tcntQ >= period - 1'b1);

  always_comb begin
    curSkip   = '0;
    firedNext = firedQ;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (levelQ == LVL_W'(i)) begin
        curSkip      = skipQ[i];
        firedNext[i] = 1'b1;
      end
    end
    levelSum  = {1'b0, levelQ} + SUM_W'(1) + SUM_W'(curSkip);
    nextLevel = (levelSum >= LVL_MAX_S) ? LVL_MAX : levelSum[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ   <= '0;
      tcntQ  <= '0;
      spentQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      if (strb.timerRestart || !timerActive || usTick) preQ <= '0;
      else preQ <= preQ + 1'b1;
      if (strb.timerRestart || expire) tcntQ <= '0;
      else if (usTick) tcntQ <= tcntQ + 1'b1;
      if (strb.timerRestart) spentQ <= 1'b0;
      else if (expire && !reloadQ[RLD_AUTO_BIT]) spentQ <= 1'b1;
      if (expire) pendQ <= 1'b1;
      else if (strb.clrPend) pendQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      levelQ <= '0;
      firedQ <= '0;
    end else if (strb.start || strb.stop) begin
      runQ   <= strb.start;
      levelQ <= '0;
      firedQ <= '0;
    end else if (runQ && expire && (levelQ < LVL_MAX)) begin
      levelQ <= nextLevel;
      firedQ <= firedNext;
    end
  end

  assign actOut = firedQ & actEn;
  assign errOut = levelQ >= errThresh;
endmodule

// File: rtl/wdogTop.sv
module wdogTop
  import wdogPkg::*;
#(
  parameter int CLKS_PER_US = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqLocal,
  output logic        irqFast,
  output logic        irqRemote,
  output logic        rstDebug,
  output logic        rstPor,
  output logic        errOut
);
  strobe_t               strb;
  skipArr_t              skipQ;
  logic [31:0]           reloadQ, cfgQ;
  logic                  pendQ, runQ, unlockedQ, cfgLocked;
  logic [LVL_W-1:0]      levelQ;
  logic [NUM_LEVELS-1:0] firedQ, actOut;

  wdogCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .pendQ(pendQ), .localHit(firedQ[0]), .busRdata(busRdata), .reloadQ(reloadQ),
    .cfgQ(cfgQ), .skipQ(skipQ), .strb(strb), .unlockedQ(unlockedQ), .cfgLocked(cfgLocked)
  );

  wdogDatapath #(.CLKS_PER_US(CLKS_PER_US)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadQ(reloadQ),
    .actEn(cfgQ[CFG_ACT_LSB +: NUM_LEVELS]), .errThresh(cfgQ[CFG_THR_LSB +: 3]),
    .skipQ(skipQ), .pendQ(pendQ), .runQ(runQ), .levelQ(levelQ), .firedQ(firedQ),
    .actOut(actOut), .errOut(errOut)
  );

  assign {rstPor, rstDebug, irqRemote, irqFast, irqLocal} = actOut;
endmodule

// File: rtl/wdogChecker.sv
module wdogChecker
  import wdogPkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWe,
  input logic [2:0]            busAddr,
  input logic [31:0]           busWdata,
  input logic                  unlockedQ,
  input logic                  cfgLocked,
  input logic [31:0]           cfgQ,
  input logic [31:0]           reloadQ,
  input logic                  pendQ,
  input logic                  runQ,
  input logic [LVL_W-1:0]      levelQ,
  input logic [NUM_LEVELS-1:0] firedQ
);
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    cfgLocked |=> $stable(cfgQ)); // R11

  AST_STOP_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_CMD && busWdata == 32'h2 && !unlockedQ && runQ) |=> runQ); // R7

  AST_STOP_WITH_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_CMD && busWdata == 32'h2 && unlockedQ) |=> (!runQ && firedQ == '0)); // R7

  AST_KEY_SINGLE_USE: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr != ADDR_UNLOCK) |=> !unlockedQ); // R8

  AST_START_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_CMD && busWdata == 32'h1) |=> (levelQ == '0 && firedQ == '0 && runQ)); // R6

  AST_LEVEL_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !(busWe && busAddr == ADDR_CMD)) |=> (levelQ >= $past(levelQ))); // R4

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= LVL_W'(NUM_LEVELS)); // R4

  AST_ZERO_PERIOD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (reloadQ[PERIOD_W-1:0] == '0 && !pendQ) |=> !pendQ); // R3
endmodule

bind wdogTop wdogChecker uChk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .unlockedQ(unlockedQ), .cfgLocked(cfgLocked), .cfgQ(cfgQ), .reloadQ(reloadQ),
  .pendQ(pendQ), .runQ(runQ), .levelQ(levelQ), .firedQ(firedQ)
);

// File: tb/tb_wdogTop.sv
module tb_wdogTop;
  localparam int CLKS = 4;
  localparam int T = 16;  // period of 4 us at CLKS clocks per us

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqLocal, irqFast, irqRemote, rstDebug, rstPor, errOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdogTop #(.CLKS_PER_US(CLKS)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqLocal(irqLocal), .irqFast(irqFast), .irqRemote(irqRemote),
    .rstDebug(rstDebug), .rstPor(rstPor), .errOut(errOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {27'd0, rstPor, rstDebug, irqRemote, irqFast, irqLocal};
  endfunction

  task automatic doStop();
    wr(3'd5, 32'h0000_C45A);
    wr(3'd4, 32'h2);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R4 reset outputs", outs(), 32'h0);
    check("R5 reset errOut", {31'd0, errOut}, 32'h0);
    rd(3'd2, d); check("R5 config reset value", d, 32'h0070_0000);
    rd(3'd3, d); check("R10 status after reset", d, 32'h0);
  endtask

  task automatic testTimer();
    logic [31:0] d;
    wr(3'd0, 32'hC000_0004);
    rd(3'd0, d); check("R12 reload readback", d, 32'hC000_0004);
    waitCyc(T + T/2);
    rd(3'd1, d); check("R2 pending set by expiry", d, 32'h4000_0000);
    check("R4 no action while stopped", outs(), 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h4000_0000);
    rd(3'd1, d); check("R2 pending cleared by write-1", d, 32'h0);
    wr(3'd0, 32'h8000_0000);
    wr(3'd4, 32'h1);
    waitCyc(4 * T);
    rd(3'd1, d); check("R3 zero period no pending", d, 32'h0);
    rd(3'd3, d); check("R3 zero period no level", d, 32'h0);
    doStop();
  endtask

  task automatic testEscalate();
    logic [31:0] d;
    wr(3'd2, 32'h0031_E010);  // local disabled, threshold 3
    wr(3'd0, 32'hC000_0004);
    wr(3'd4, 32'h1);
    waitCyc(T/2);
    check("R4 level0 outputs", outs(), 32'h0);
    check("R5 level0 errOut", {31'd0, errOut}, 32'h0);
    waitCyc(T);
    check("R4 local disabled stays low", outs(), 32'h0);
    rd(3'd3, d); check("R10 local level reached", d, 32'h2);
    check("R5 level1 errOut", {31'd0, errOut}, 32'h0);
    waitCyc(T);
    check("R4 level2 fast", outs(), 32'h02);
    waitCyc(T);
    check("R4 level3 remote", outs(), 32'h06);
    check("R5 errOut at threshold", {31'd0, errOut}, 32'h1);
    waitCyc(T);
    check("R4 level4 debug", outs(), 32'h0E);
    waitCyc(T);
    check("R4 level5 por", outs(), 32'h1E);
    waitCyc(2 * T);
    check("R4 saturated", outs(), 32'h1E);
  endtask

  task automatic testStopGuard();
    logic [31:0] d;
    wr(3'd4, 32'h2);
    waitCyc(1);
    check("R7 stop without key ignored", outs(), 32'h1E);
    wr(3'd5, 32'h0000_C45A);
    wr(3'd6, 32'h0);
    wr(3'd4, 32'h2);
    check("R8 key broken by other write", outs(), 32'h1E);
    doStop();
    check("R7 keyed stop clears outputs", outs(), 32'h0);
    rd(3'd3, d); check("R7 keyed stop clears status", d, 32'h0);
    waitCyc(3 * T);
    check("R7 stays stopped", outs(), 32'h0);
  endtask

  task automatic testSkip();
    logic [31:0] d;
    wr(3'd6, 32'h0000_0002);
    rd(3'd6, d); check("R9 skip readback", d, 32'h2);
    wr(3'd4, 32'h1);
    waitCyc(T + T/2);
    rd(3'd3, d); check("R9 stage0 fired", d, 32'h2);
    check("R9 stage0 outputs", outs(), 32'h0);
    waitCyc(T);
    check("R9 fast and remote bypassed", outs(), 32'h08);
    waitCyc(T);
    check("R9 por after debug", outs(), 32'h18);
    wr(3'd4, 32'h1);
    check("R6 start clears actions", outs(), 32'h0);
    rd(3'd3, d); check("R6 start clears status", d, 32'h0);
    waitCyc(T/2);
    rd(3'd3, d); check("R6 full period restarted", d, 32'h0);
    waitCyc(T);
    rd(3'd3, d); check("R6 first level after restart", d, 32'h2);
    doStop();
  endtask

  task automatic testOneShot();
    logic [31:0] d;
    wr(3'd6, 32'h0);
    wr(3'd0, 32'h8000_0004);
    wr(3'd4, 32'h1);
    waitCyc(T + T/2);
    rd(3'd3, d); check("R1 one-shot fires once", d, 32'h2);
    waitCyc(2 * T);
    check("R1 one-shot no second expiry", outs(), 32'h0);
    doStop();
  endtask

  task automatic testLock();
    logic [31:0] d;
    wr(3'd2, 32'h0071_F010);
    rd(3'd2, d); check("R11 config written", d, 32'h0071_F010);
    wr(3'd2, 32'h0);
    rd(3'd2, d); check("R11 locked config ignores write", d, 32'h0071_F010);
    wr(3'd0, 32'hC000_0004);
    wr(3'd4, 32'h1);
    waitCyc(T + T/2);
    check("R4 local interrupt enabled", outs(), 32'h01);
    doStop();
  endtask

  initial begin
    fork
      begin
        waitCyc(100000);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog: actual=timeout expected=completion");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testTimer();
    testEscalate();
    testStopGuard();
    testSkip();
    testOneShot();
    testLock();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule